// File: doc/BRIEF.md
# Domain Power Request Sequencer

This block carries out one complete power-up or power-down transaction for a single power domain. It acts as a master on a plain 32-bit register bus that reaches the power controller's register bank. A requester gives a start strobe together with the direction, the domain's channel base offset, its channel bit, its interrupt bit, and an optional external-request mask (an address and a value). The sequencer then performs the following bus steps in order:

- It raises the external-request mask, if the mask value is nonzero.
- It arms the domain's interrupt source as enabled but masked.
- It clears any stale completion flag.
- It waits until the controller is ready, then submits the request.
- It resubmits while the channel reports a rejection.
- It waits for the completion flag, then clears it.
- It drops the mask.

When the transaction ends, the block pulses done for one cycle and presents a status code. All time bounds count a one-microsecond tick input rather than clock cycles. The sequencer therefore keeps the same timing at any clock frequency.

Top module: `pwr_req_sequencer`

## Requirements
- R1: When the mask value is nonzero, the first bus operation after an accepted start is a write of that value to the mask address, and the last bus operation of the transaction is a write of zero to the same address, on every exit path. When the mask value is zero, the mask address is never written.
- R2: The sequencer reads the interrupt mask register (offset 0x10) and writes it back with the domain's interrupt bit set, keeping all other bits. It then does the same to the interrupt enable register (offset 0x0C). Then it writes the one-hot domain bit to the interrupt clear register (offset 0x08).
- R3: Before each submission, the sequencer reads the common status register (offset 0x00). Bit 1 is ready-for-power-up and bit 0 is ready-for-power-down. It reads once at the start and once more after each tick, up to READY_LIMIT ticks, so there are at most READY_LIMIT+1 reads. If the bit stays clear, the transaction ends with status busy and nothing is submitted.
- R4: A submission writes the one-hot channel bit to the channel base plus 0x0C for power-up, or to the channel base plus 0x04 for power-down.
- R5: After each submission, the sequencer reads the channel error register at the channel base plus 0x14. If the channel bit is clear, the request is accepted. If it is set, the sequencer waits one tick and resubmits. After RETRY_LIMIT rejected submissions, the transaction ends with io-error and the completion flag is not cleared a second time.
- R6: After acceptance, the sequencer reads the interrupt status register (offset 0x04) once and then after each tick, up to DONE_LIMIT ticks, so there are at most DONE_LIMIT+1 reads. If the domain bit is never set, the status is io-error.
- R7: After the completion poll, the sequencer writes the domain bit to the clear register, both on success and on timeout.
- R8: done_o is high for exactly one cycle per transaction. status_o uses the codes 0 = ok, 1 = busy and 2 = io-error, and holds its value until the next accepted start.
- R9: A start strobe that arrives while a transaction is in progress is ignored.
- R10: Each read waits for bus_rvalid_i, and only the data present in that cycle is used. Read latency may be any number of cycles.
- R11: The retry and poll counters restart with every transaction, so one transaction's earlier retries and waits do not shorten the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; taken only when idle |
| power_on_i | input | 1 | 1 = power up, 0 = power down |
| chan_offs_i | input | AW (12) | Base address of the domain's channel registers |
| chan_bit_i | input | IDXW (5) | Domain bit index within the channel registers |
| irq_bit_i | input | IDXW (5) | Domain bit index within the interrupt registers |
| xmask_offs_i | input | AW (12) | Address of the external-request mask register |
| xmask_val_i | input | DW (32) | Mask value; zero skips masking |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| bus_valid_o | output | 1 | Bus operation request, one cycle |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW (12) | Bus address |
| bus_wdata_o | output | DW (32) | Write data |
| bus_rdata_i | input | DW (32) | Read data, valid with bus_rvalid_i |
| bus_rvalid_i | input | 1 | Read data valid |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result: 0 ok, 1 busy, 2 io-error |

## Verification
The hardest conditions to reach are the exhausted retry loop and the completion timeout. In both, the controller has to keep refusing or stay silent across many tick-paced polls. Meanwhile the mask must still be cleared, and the clear register must be written exactly the right number of times.

The bench register model holds a programmable count of rejections, a switch that withholds completion, and per-direction ready bits. Counting status and interrupt-status reads then pins down the exact poll bounds. Running an exhausted transaction immediately before a transaction that needs retries shows that the counters restart. A long, variable read latency, with garbage on the data bus outside valid cycles, exposes any read that does not wait for bus_rvalid_i.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_BUSY  = 2'd1,
    RES_IOERR = 2'd2
  } pwr_res_e;

  typedef enum logic [4:0] {
    S_IDLE, S_XSET,
    S_IMR_RD, S_IMR_WT, S_IMR_WR,
    S_IER_RD, S_IER_WT, S_IER_WR,
    S_CLR0,
    S_RDY_RD, S_RDY_WT, S_RDY_TICK,
    S_SUBMIT, S_ERR_RD, S_ERR_WT, S_RETRY_CHK, S_RETRY_TICK,
    S_CMP_RD, S_CMP_WT, S_CMP_TICK,
    S_CLR1, S_XCLR, S_FIN
  } pwr_state_e;
endpackage

// File: rtl/pwr_bound_cnt.sv
module pwr_bound_cnt #(
  parameter int LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (inc_i && !at_limit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == CW'(LIMIT));

  // R11
  no_inc_at_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_limit_o |-> !inc_i);
endmodule

// File: rtl/pwr_req_sequencer.sv
module pwr_req_sequencer
  import pwr_seq_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter int READY_LIMIT = 100,
  parameter int RETRY_LIMIT = 100,
  parameter int DONE_LIMIT  = 1000,
  parameter int OFS_STAT    = 'h00,
  parameter int OFS_ISR     = 'h04,
  parameter int OFS_ICLR    = 'h08,
  parameter int OFS_IEN     = 'h0C,
  parameter int OFS_IMSK    = 'h10,
  parameter int CH_OFF_REQ  = 'h04,
  parameter int CH_ON_REQ   = 'h0C,
  parameter int CH_ERR      = 'h14,
  localparam int IDXW       = $clog2(DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            power_on_i,
  input  logic [AW-1:0]   chan_offs_i,
  input  logic [IDXW-1:0] chan_bit_i,
  input  logic [IDXW-1:0] irq_bit_i,
  input  logic [AW-1:0]   xmask_offs_i,
  input  logic [DW-1:0]   xmask_val_i,
  input  logic            tick_us_i,
  output logic            bus_valid_o,
  output logic            bus_write_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  input  logic            bus_rvalid_i,
  output logic            done_o,
  output logic [1:0]      status_o
);
  pwr_state_e state_q, state_d;
  pwr_res_e   res_q, res_d;

  logic            on_q;
  logic [AW-1:0]   chan_offs_q, xoffs_q;
  logic [IDXW-1:0] chan_bit_q, irq_bit_q;
  logic [DW-1:0]   xval_q, rdata_q;

  logic [DW-1:0] irq_mask, chan_mask, rdy_mask;
  logic          accept;
  logic          rdy_clr, rdy_inc, rdy_lim;
  logic          att_inc, att_lim;
  logic          cmp_inc, cmp_lim;

  assign irq_mask  = DW'(1) << irq_bit_q;
  assign chan_mask = DW'(1) << chan_bit_q;
  assign rdy_mask  = on_q ? DW'(2) : DW'(1);
  assign accept    = (state_q == S_IDLE) && start_i;

  // transaction context
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q        <= 1'b0;
      chan_offs_q <= '0;
      xoffs_q     <= '0;
      chan_bit_q  <= '0;
      irq_bit_q   <= '0;
      xval_q      <= '0;
    end else if (accept) begin
      on_q        <= power_on_i;
      chan_offs_q <= chan_offs_i;
      xoffs_q     <= xmask_offs_i;
      chan_bit_q  <= chan_bit_i;
      irq_bit_q   <= irq_bit_i;
      xval_q      <= xmask_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      res_q   <= RES_OK;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (bus_rvalid_i) rdata_q <= bus_rdata_i;
    end
  end

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        res_d   = RES_OK;
        state_d = (xmask_val_i != '0) ? S_XSET : S_IMR_RD;
      end
      S_XSET:   state_d = S_IMR_RD;
      S_IMR_RD: state_d = S_IMR_WT;
      S_IMR_WT: if (bus_rvalid_i) state_d = S_IMR_WR;
      S_IMR_WR: state_d = S_IER_RD;
      S_IER_RD: state_d = S_IER_WT;
      S_IER_WT: if (bus_rvalid_i) state_d = S_IER_WR;
      S_IER_WR: state_d = S_CLR0;
      S_CLR0:   state_d = S_RDY_RD;
      S_RDY_RD: state_d = S_RDY_WT;
      S_RDY_WT: if (bus_rvalid_i) begin
        if ((bus_rdata_i & rdy_mask) != '0) state_d = S_SUBMIT;
        else if (rdy_lim) begin
          res_d   = RES_BUSY;
          state_d = S_XCLR;
        end else state_d = S_RDY_TICK;
      end
      S_RDY_TICK: if (tick_us_i) state_d = S_RDY_RD;
      S_SUBMIT:   state_d = S_ERR_RD;
      S_ERR_RD:   state_d = S_ERR_WT;
      S_ERR_WT: if (bus_rvalid_i) begin
        state_d = ((bus_rdata_i & chan_mask) == '0) ? S_CMP_RD : S_RETRY_CHK;
      end
      S_RETRY_CHK: begin
        if (att_lim) begin
          res_d   = RES_IOERR;
          state_d = S_XCLR;
        end else state_d = S_RETRY_TICK;
      end
      S_RETRY_TICK: if (tick_us_i) state_d = S_RDY_RD;
      S_CMP_RD: state_d = S_CMP_WT;
      S_CMP_WT: if (bus_rvalid_i) begin
        if ((bus_rdata_i & irq_mask) != '0) state_d = S_CLR1;
        else if (cmp_lim) begin
          res_d   = RES_IOERR;
          state_d = S_CLR1;
        end else state_d = S_CMP_TICK;
      end
      S_CMP_TICK: if (tick_us_i) state_d = S_CMP_RD;
      S_CLR1:     state_d = S_XCLR;
      S_XCLR:     state_d = S_FIN;
      S_FIN:      state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  // bus command per state
  always_comb begin
    bus_valid_o = 1'b0;
    bus_write_o = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_XSET:   begin bus_valid_o = 1'b1; bus_write_o = 1'b1; bus_addr_o = xoffs_q; bus_wdata_o = xval_q; end
      S_IMR_RD: begin bus_valid_o = 1'b1; bus_addr_o = AW'(OFS_IMSK); end
      S_IMR_WR: begin bus_valid_o = 1'b1; bus_write_o = 1'b1; bus_addr_o = AW'(OFS_IMSK); bus_wdata_o = rdata_q | irq_mask; end
      S_IER_RD: begin bus_valid_o = 1'b1; bus_addr_o = AW'(OFS_IEN); end
      S_IER_WR: begin bus_valid_o = 1'b1; bus_write_o = 1'b1; bus_addr_o = AW'(OFS_IEN); bus_wdata_o = rdata_q | irq_mask; end
      S_CLR0, S_CLR1: begin bus_valid_o = 1'b1; bus_write_o = 1'b1; bus_addr_o = AW'(OFS_ICLR); bus_wdata_o = irq_mask; end
      S_RDY_RD: begin bus_valid_o = 1'b1; bus_addr_o = AW'(OFS_STAT); end
      S_SUBMIT: begin
        bus_valid_o = 1'b1;
        bus_write_o = 1'b1;
        bus_addr_o  = chan_offs_q + (on_q ? AW'(CH_ON_REQ) : AW'(CH_OFF_REQ));
        bus_wdata_o = chan_mask;
      end
      S_ERR_RD: begin bus_valid_o = 1'b1; bus_addr_o = chan_offs_q + AW'(CH_ERR); end
      S_CMP_RD: begin bus_valid_o = 1'b1; bus_addr_o = AW'(OFS_ISR); end
      S_XCLR: if (xval_q != '0) begin
        bus_valid_o = 1'b1; bus_write_o = 1'b1; bus_addr_o = xoffs_q; bus_wdata_o = '0;
      end
      default: ;
    endcase
  end

  assign rdy_clr = accept || (state_q == S_RETRY_TICK && tick_us_i);
  assign rdy_inc = (state_q == S_RDY_TICK) && tick_us_i;
  assign att_inc = (state_q == S_ERR_WT) && bus_rvalid_i && ((bus_rdata_i & chan_mask) != '0);
  assign cmp_inc = (state_q == S_CMP_TICK) && tick_us_i;

  pwr_bound_cnt #(.LIMIT(READY_LIMIT)) u_rdy_cnt (
    .clk_i, .rst_ni, .clr_i(rdy_clr), .inc_i(rdy_inc), .at_limit_o(rdy_lim));
  pwr_bound_cnt #(.LIMIT(RETRY_LIMIT)) u_att_cnt (
    .clk_i, .rst_ni, .clr_i(accept), .inc_i(att_inc), .at_limit_o(att_lim));
  pwr_bound_cnt #(.LIMIT(DONE_LIMIT)) u_cmp_cnt (
    .clk_i, .rst_ni, .clr_i(accept), .inc_i(cmp_inc), .at_limit_o(cmp_lim));

  assign done_o   = (state_q == S_FIN);
  assign status_o = res_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || (state_q == S_IDLE && !start_i)) |=> $stable(status_o));
  // R1
  xmask_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && xmask_val_i != '0) |=>
      (bus_valid_o && bus_write_o && bus_addr_o == $past(xmask_offs_i)));
  // R4
  submit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_write_o &&
     (bus_addr_o == chan_offs_q + AW'(CH_ON_REQ) || bus_addr_o == chan_offs_q + AW'(CH_OFF_REQ)) &&
     state_q != S_XSET && state_q != S_XCLR) |-> $onehot(bus_wdata_o));
  // R10
  read_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_write_o) |=> !bus_valid_o);
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && state_q != S_FIN) |=> state_q != S_IDLE || $past(state_q) == S_FIN);
endmodule

// File: tb/pwr_req_sequencer_test.sv
module pwr_req_sequencer_test;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int RDY_L = 4;
  localparam int RTY_L = 3;
  localparam int CMP_L = 6;
  localparam logic [AW-1:0] A_STAT = 12'h000, A_ISR = 12'h004, A_ICLR = 12'h008,
                            A_IEN = 12'h00C, A_IMSK = 12'h010, A_XM = 12'h080;

  logic clk = 0, rst_n = 0;
  logic start = 0, pon = 0, tick = 0;
  logic [AW-1:0] coffs = '0, xoffs = A_XM;
  logic [4:0] cbit = '0, ibit = '0;
  logic [DW-1:0] xval = '0;
  logic bvalid, bwrite, rvalid, done;
  logic [AW-1:0] baddr;
  logic [DW-1:0] bwdata, rdata, rdata_q;
  logic [1:0] status;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwr_req_sequencer #(.AW(AW), .DW(DW), .READY_LIMIT(RDY_L), .RETRY_LIMIT(RTY_L),
                      .DONE_LIMIT(CMP_L)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .power_on_i(pon),
    .chan_offs_i(coffs), .chan_bit_i(cbit), .irq_bit_i(ibit),
    .xmask_offs_i(xoffs), .xmask_val_i(xval), .tick_us_i(tick),
    .bus_valid_o(bvalid), .bus_write_o(bwrite), .bus_addr_o(baddr), .bus_wdata_o(bwdata),
    .bus_rdata_i(rdata), .bus_rvalid_i(rvalid), .done_o(done), .status_o(status));

  // microsecond tick every 4 clocks
  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
  end

  // register model configuration (driven by tasks)
  logic cfg_load = 0;
  logic [DW-1:0] cfg_imr = '0, cfg_ier = '0;
  int  cfg_reject = 0, rd_lat = 1;
  logic rdy_on = 1, rdy_off = 1, cmp_en = 1;

  logic [DW-1:0] imr, ier, isr, xm;
  int reject_left, rd_tmr, cmp_tmr;
  logic rd_pend, cmp_pend;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] wr_addr [0:255];
  logic [DW-1:0] wr_data [0:255];
  int wr_n = 0, n_stat_rd = 0, n_isr_rd = 0, done_cnt = 0, long_pulse = 0;
  logic done_d = 0;

  assign rdata = rvalid ? rdata_q : 32'hDEADBEEF;

  always @(posedge clk) begin
    rvalid <= 1'b0;
    done_d <= done;
    if (done) done_cnt <= done_cnt + 1;
    if (done && done_d) long_pulse <= long_pulse + 1;
    if (cfg_load) begin
      imr <= cfg_imr; ier <= cfg_ier; isr <= '0; xm <= '0;
      reject_left <= cfg_reject; rd_pend <= 0; cmp_pend <= 0;
    end else begin
      if (cmp_pend) begin
        if (cmp_tmr == 0) begin isr <= isr | (32'd1 << ibit); cmp_pend <= 0; end
        else cmp_tmr <= cmp_tmr - 1;
      end
      if (rd_pend) begin
        if (rd_tmr <= 1) begin
          rvalid <= 1'b1; rd_pend <= 0;
          if (rd_addr == A_STAT) begin rdata_q <= {30'd0, rdy_on, rdy_off}; n_stat_rd <= n_stat_rd + 1; end
          else if (rd_addr == A_ISR) begin rdata_q <= isr; n_isr_rd <= n_isr_rd + 1; end
          else if (rd_addr == A_IMSK) rdata_q <= imr;
          else if (rd_addr == A_IEN) rdata_q <= ier;
          else if (rd_addr == coffs + 12'h014) begin
            if (reject_left > 0) begin
              rdata_q <= 32'd1 << cbit; reject_left <= reject_left - 1;
            end else begin
              rdata_q <= '0;
              if (cmp_en) begin cmp_pend <= 1; cmp_tmr <= 5; end
            end
          end else rdata_q <= '0;
        end else rd_tmr <= rd_tmr - 1;
      end
      if (bvalid && !bwrite) begin rd_pend <= 1; rd_addr <= baddr; rd_tmr <= rd_lat; end
      if (bvalid && bwrite) begin
        if (wr_n < 256) begin wr_addr[wr_n] <= baddr; wr_data[wr_n] <= bwdata; end
        wr_n <= wr_n + 1;
        if (baddr == A_ICLR) isr <= isr & ~bwdata;
        else if (baddr == A_IEN) ier <= bwdata;
        else if (baddr == A_IMSK) imr <= bwdata;
        else if (baddr == xoffs) xm <= bwdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int cnt_wr(input int base, input logic [AW-1:0] a);
    int c = 0;
    for (int i = base; i < wr_n; i++) if (wr_addr[i] == a) c++;
    return c;
  endfunction

  int base, sr0, ir0, dc0;

  task automatic setup(input logic on, input logic [AW-1:0] co, input int cb, input int ib,
                       input logic [DW-1:0] xv, input logic [DW-1:0] pimr, input logic [DW-1:0] pier,
                       input int rej);
    @(negedge clk);
    pon = on; coffs = co; cbit = 5'(cb); ibit = 5'(ib); xval = xv;
    cfg_imr = pimr; cfg_ier = pier; cfg_reject = rej; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  // second_at > 0: issue an extra start that many cycles after the first
  task automatic run_tx(input int second_at);
    int cyc;
    base = wr_n; sr0 = n_stat_rd; ir0 = n_isr_rd; dc0 = done_cnt;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      if (second_at > 0 && cyc == second_at) begin
        start = 1; pon = ~pon; coffs = 12'h200; cbit = 5'd5;
        @(negedge clk); start = 0;
      end else @(negedge clk);
      cyc++;
    end
    if (!done) begin n_tests++; n_fail++; $display("FAIL R8: actual no done expected done"); end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 reset done", 32'(done), 0);
    chk("R8 reset status", 32'(status), 0);
    chk("R10 reset bus idle", 32'(bvalid), 0);
  endtask

  task automatic t_on_basic();
    rdy_on = 1; rdy_off = 0; cmp_en = 1; rd_lat = 1;
    setup(1, 12'h100, 3, 7, 32'h33, 32'h100, 32'h4, 0);
    run_tx(0);
    chk("R8 status ok", 32'(status), 0);
    chk("R1 first write addr", 32'(wr_addr[base]), 32'(A_XM));
    chk("R1 first write data", wr_data[base], 32'h33);
    chk("R2 imr rmw", wr_data[base+1], 32'h180);
    chk("R2 ier rmw", wr_data[base+2], 32'h84);
    chk("R2 clear addr", 32'(wr_addr[base+3]), 32'(A_ICLR));
    chk("R4 submit addr on", 32'(wr_addr[base+4]), 32'h10C);
    chk("R4 submit data", wr_data[base+4], 32'h8);
    chk("R7 clear after completion", 32'(wr_addr[base+5]), 32'(A_ICLR));
    chk("R1 mask dropped last", wr_data[base+6], 0);
    chk("R1 write count", 32'(wr_n - base), 7);
    chk("R8 one done pulse", 32'(done_cnt - dc0), 1);
    chk("R8 pulse width", 32'(long_pulse), 0);
    repeat (10) @(negedge clk);
    chk("R8 status held", 32'(status), 0);
  endtask

  task automatic t_off_nomask();
    rdy_on = 0; rdy_off = 1; cmp_en = 1; rd_lat = 2;
    setup(0, 12'h200, 5, 2, 32'h0, 32'h0, 32'h0, 0);
    run_tx(0);
    chk("R3 off uses bit0", 32'(status), 0);
    chk("R1 no mask write", 32'(cnt_wr(base, A_XM)), 0);
    chk("R4 submit off addr", 32'(cnt_wr(base, 12'h204)), 1);
    chk("R4 submit off data", wr_data[base+3], 32'h20);
    chk("R2 first is imr", 32'(wr_addr[base]), 32'(A_IMSK));
  endtask

  task automatic t_busy();
    rdy_on = 0; rdy_off = 1; cmp_en = 1; rd_lat = 1;
    setup(1, 12'h100, 3, 7, 32'h5, 32'h0, 32'h0, 0);
    run_tx(0);
    chk("R3 busy status", 32'(status), 1);
    chk("R3 ready reads", 32'(n_stat_rd - sr0), RDY_L + 1);
    chk("R3 no submit", 32'(cnt_wr(base, 12'h10C)), 0);
    chk("R7 single clear on busy", 32'(cnt_wr(base, A_ICLR)), 1);
    chk("R1 mask zero on busy", 32'(wr_addr[wr_n-1]), 32'(A_XM));
    repeat (20) @(negedge clk);
    chk("R8 busy held", 32'(status), 1);
  endtask

  task automatic t_retry_exhaust();
    rdy_on = 1; rdy_off = 1; cmp_en = 1; rd_lat = 1;
    setup(1, 12'h100, 3, 7, 32'h9, 32'h0, 32'h0, 99);
    run_tx(0);
    chk("R5 ioerr after retries", 32'(status), 2);
    chk("R5 submit count", 32'(cnt_wr(base, 12'h10C)), RTY_L);
    chk("R5 no second clear", 32'(cnt_wr(base, A_ICLR)), 1);
    chk("R1 mask zero on ioerr", wr_data[wr_n-1], 0);
  endtask

  task automatic t_retry_ok();
    rdy_on = 1; rdy_off = 1; cmp_en = 1; rd_lat = 1;
    setup(1, 12'h100, 3, 7, 32'h0, 32'h0, 32'h0, RTY_L - 1);
    run_tx(0);
    chk("R11 counters restart", 32'(status), 0);
    chk("R5 resubmitted", 32'(cnt_wr(base, 12'h10C)), RTY_L);
  endtask

  task automatic t_cmp_timeout();
    rdy_on = 1; rdy_off = 1; cmp_en = 0; rd_lat = 1;
    setup(0, 12'h100, 1, 4, 32'h7, 32'h0, 32'h0, 0);
    run_tx(0);
    chk("R6 completion timeout", 32'(status), 2);
    chk("R6 isr reads", 32'(n_isr_rd - ir0), CMP_L + 1);
    chk("R7 clear on timeout", 32'(cnt_wr(base, A_ICLR)), 2);
    chk("R1 mask zero last", 32'(wr_addr[wr_n-1]), 32'(A_XM));
    cmp_en = 1;
  endtask

  task automatic t_ignore_start();
    rdy_on = 1; rdy_off = 1; cmp_en = 1; rd_lat = 3;
    setup(1, 12'h100, 3, 7, 32'h0, 32'h0, 32'h0, 0);
    run_tx(6);
    chk("R9 single done", 32'(done_cnt - dc0), 1);
    chk("R9 original submit", 32'(cnt_wr(base, 12'h10C)), 1);
    chk("R9 no foreign submit", 32'(cnt_wr(base, 12'h204)), 0);
  endtask

  task automatic t_slow_read();
    rdy_on = 1; rdy_off = 0; cmp_en = 1; rd_lat = 7;
    setup(1, 12'h100, 0, 6, 32'h0, 32'h0F0F, 32'h0, 0);
    run_tx(0);
    chk("R10 slow read status", 32'(status), 0);
    chk("R10 imr uses valid data", wr_data[base], 32'h0F4F);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_on_basic();
    t_off_nomask();
    t_busy();
    t_retry_exhaust();
    t_retry_ok();
    t_cmp_timeout();
    t_ignore_start();
    t_slow_read();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule